// File: doc/BRIEF.md
# Chained Block Descriptor Walker

This block runs the descriptor side of one DMA channel. Software leaves a chain of seven-word block descriptors in memory and pulses `start` with a pointer to the first one. The walker reads the first five words of the current descriptor, one word per request, in ascending address order. It hands the source address, destination address, element count and direction to the transfer engine over a valid/ready handshake, then waits for the engine's completion pulse. After that it writes three words back into the descriptor: the control-high word with its done flag set, and the two status words the engine reported. It then either follows the next-pointer or stops.

A next-pointer is split in two parts. Its low two bits choose the bus master used for the following list accesses. Its upper thirty bits give the word address of the next descriptor. Chaining continues only when one of the two chaining bits in control-low is set and the address part of the next-pointer is non-zero. A per-descriptor interrupt-enable bit makes the walker pulse `blk_irq` once that block's write-back ends, and `xfer_done` pulses when the whole walk is over. An abort input lets the word access in flight finish, then drops the channel to idle with no further write-back.

Top module: `dma_chain_walker`

## Requirements
- R1: Out of reset the walker is idle: `busy`, `rd_req_valid`, `wr_valid`, `blk_valid`, `blk_irq` and `xfer_done` are all low.
- R2: On `start` the walker reads five words at byte offsets 0, 4, 8, 12, 16 from the descriptor address (pointer bits [31:2] followed by two zero bits), strictly in that order with one read outstanding. `rd_req_master` carries pointer bits [1:0], and every read address is word aligned.
- R3: After the fifth word returns, `blk_valid` rises and presents word 0 on `blk_src` and word 1 on `blk_dst`. It also presents control-high bits [11:0] on `blk_size` and control-low bits [21:20] on `blk_dir`, where 0 is memory to memory, 1 is memory to peripheral, 2 is peripheral to memory and 3 is peripheral to peripheral. These stay stable until `blk_ready`.
- R4: After `blk_done` the walker makes exactly three writes. The first goes to offset 16 and carries the fetched control-high word with bit 12 set and all other bits unchanged. The second goes to offset 20 with `blk_src_stat`, and the third to offset 24 with `blk_dst_stat`. Offsets 0 to 12 are never written.
- R5: When control-low bit 27 or bit 28 is set and next-pointer bits [31:2] are non-zero, the next fetch starts at that pointer, with its bits [1:0] as the new master select.
- R6: With control-low bits 27 and 28 both clear, the walk ends after the current block even if the next-pointer is non-zero. A next-pointer whose bits [31:2] are zero also ends the walk, whatever its bits [1:0] hold. `xfer_done` pulses for one cycle, the cycle after the last write is accepted, and `busy` is low in that cycle.
- R7: `blk_irq` pulses for one cycle after a descriptor's third write-back only when that descriptor's control-low bit 0 is set.
- R8: `abort` while busy lets the read or write handshake already under way finish, then returns the walker to idle. No further reads, hand-offs or write-backs follow, and there is no `xfer_done` or `blk_irq`. During the block wait it goes idle at once.
- R9: `start` is ignored while the walker is busy.
- R10: `rd_req_valid` and `wr_valid` hold their address, master and data stable until the matching ready. At most one of `rd_req_valid`, `wr_valid`, `blk_valid` is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk at `head_ptr` |
| head_ptr | input | 32 | First next-pointer: [31:2] address, [1:0] master |
| abort | input | 1 | Stop the walk after the current word access |
| busy | output | 1 | Walk in progress |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | 32 | Read byte address |
| rd_req_master | output | 2 | Bus master for list access |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 32 | Read data word |
| wr_valid | output | 1 | Write-back valid |
| wr_ready | input | 1 | Write-back accepted |
| wr_addr | output | 32 | Write-back byte address |
| wr_master | output | 2 | Bus master for write-back |
| wr_data | output | 32 | Write-back data word |
| blk_valid | output | 1 | Block hand-off valid |
| blk_ready | input | 1 | Engine accepts the block |
| blk_src | output | 32 | Block source address |
| blk_dst | output | 32 | Block destination address |
| blk_size | output | 12 | Block length in elements |
| blk_dir | output | 2 | Transfer direction code |
| blk_done | input | 1 | Engine finished the block |
| blk_src_stat | input | 32 | Source status from the engine |
| blk_dst_stat | input | 32 | Destination status from the engine |
| blk_irq | output | 1 | Block-complete pulse |
| xfer_done | output | 1 | Walk-complete pulse |

## Verification
On every cycle the assertions check handshake stability, mutual exclusion of the three request strobes, read alignment, and phase order: a hand-off only follows a returned word, and a write-back only follows `blk_done`. They also check that `xfer_done` coincides with idle and that an abort never produces a completion pulse. Only the bench scenarios can show the full content of each walk: exact read addresses and masters, hand-off fields, write-back values, chain-following versus stopping, and which descriptors pulse `blk_irq`. The same holds for the claims that start is ignored while busy and that descriptor words 0 to 12 stay untouched.

// File: rtl/dma_chain_walker.sv
module dma_chain_walker #(
  parameter int AW     = 32,
  parameter int SIZE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     head_ptr,
  input  logic              abort,
  output logic              busy,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [AW-1:0]     rd_req_addr,
  output logic [1:0]        rd_req_master,
  input  logic              rd_rsp_valid,
  input  logic [31:0]       rd_rsp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [AW-1:0]     wr_addr,
  output logic [1:0]        wr_master,
  output logic [31:0]       wr_data,
  output logic              blk_valid,
  input  logic              blk_ready,
  output logic [AW-1:0]     blk_src,
  output logic [AW-1:0]     blk_dst,
  output logic [SIZE_W-1:0] blk_size,
  output logic [1:0]        blk_dir,
  input  logic              blk_done,
  input  logic [31:0]       blk_src_stat,
  input  logic [31:0]       blk_dst_stat,
  output logic              blk_irq,
  output logic              xfer_done
);
  localparam int DONE_BIT  = 12;
  localparam int LAST_RD   = 4;
  localparam int LAST_WR   = 2;
  localparam int WB_OFFSET = 16;

  typedef enum logic [2:0] {S_IDLE, S_RREQ, S_RWAIT, S_BLK, S_BWAIT, S_WB} st_t;

  st_t          st;
  logic [AW-3:0] base;
  logic [1:0]   mst;
  logic [2:0]   idx;
  logic [31:0]  w_src, w_dst, w_llp, w_clo, w_chi, s_stat, d_stat;
  logic         abort_q;

  wire          stop_now = abort | abort_q;
  wire          chain_en = w_clo[27] | w_clo[28];
  wire          next_ok  = |w_llp[31:2];
  wire [AW-1:0] desc_addr = {base, 2'b00};
  wire [AW-1:0] idx_off   = AW'({idx, 2'b00});

  assign busy          = (st != S_IDLE);
  assign rd_req_valid  = (st == S_RREQ);
  assign rd_req_addr   = desc_addr + idx_off;
  assign rd_req_master = mst;
  assign wr_valid      = (st == S_WB);
  assign wr_addr       = desc_addr + AW'(WB_OFFSET) + idx_off;
  assign wr_master     = mst;
  assign wr_data       = (idx == 3'd0) ? (w_chi | (32'd1 << DONE_BIT)) :
                         (idx == 3'd1) ? s_stat : d_stat;
  assign blk_valid     = (st == S_BLK);
  assign blk_src       = AW'(w_src);
  assign blk_dst       = AW'(w_dst);
  assign blk_size      = w_chi[SIZE_W-1:0];
  assign blk_dir       = w_clo[21:20];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      base      <= '0;
      mst       <= '0;
      idx       <= '0;
      w_src     <= '0;
      w_dst     <= '0;
      w_llp     <= '0;
      w_clo     <= '0;
      w_chi     <= '0;
      s_stat    <= '0;
      d_stat    <= '0;
      abort_q   <= 1'b0;
      blk_irq   <= 1'b0;
      xfer_done <= 1'b0;
    end else begin
      blk_irq   <= 1'b0;
      xfer_done <= 1'b0;
      if (abort && st != S_IDLE) abort_q <= 1'b1;
      case (st)
        S_IDLE: begin
          abort_q <= 1'b0;
          if (start) begin
            base <= head_ptr[AW-1:2];
            mst  <= head_ptr[1:0];
            idx  <= '0;
            st   <= S_RREQ;
          end
        end
        S_RREQ: if (rd_req_ready) st <= S_RWAIT;
        S_RWAIT: if (rd_rsp_valid) begin
          case (idx)
            3'd0:    w_src <= rd_rsp_data;
            3'd1:    w_dst <= rd_rsp_data;
            3'd2:    w_llp <= rd_rsp_data;
            3'd3:    w_clo <= rd_rsp_data;
            default: w_chi <= rd_rsp_data;
          endcase
          if (stop_now)                   st <= S_IDLE;
          else if (idx == 3'(LAST_RD))    st <= S_BLK;
          else begin
            idx <= idx + 3'd1;
            st  <= S_RREQ;
          end
        end
        S_BLK: begin
          if (blk_ready)     st <= S_BWAIT;
          else if (stop_now) st <= S_IDLE;
        end
        S_BWAIT: begin
          if (stop_now) st <= S_IDLE;
          else if (blk_done) begin
            s_stat <= blk_src_stat;
            d_stat <= blk_dst_stat;
            idx    <= '0;
            st     <= S_WB;
          end
        end
        S_WB: if (wr_ready) begin
          if (stop_now) st <= S_IDLE;
          else if (idx == 3'(LAST_WR)) begin
            blk_irq <= w_clo[0];
            if (chain_en && next_ok) begin
              base <= w_llp[31:2];
              mst  <= w_llp[1:0];
              idx  <= '0;
              st   <= S_RREQ;
            end else begin
              xfer_done <= 1'b1;
              st        <= S_IDLE;
            end
          end else idx <= idx + 3'd1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_chain_walker_chk.sv
module dma_chain_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        abort,
  input logic        busy,
  input logic        rd_req_valid,
  input logic        rd_req_ready,
  input logic [31:0] rd_req_addr,
  input logic [1:0]  rd_req_master,
  input logic        rd_rsp_valid,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic [31:0] wr_addr,
  input logic [31:0] wr_data,
  input logic        blk_valid,
  input logic        blk_ready,
  input logic [31:0] blk_src,
  input logic [31:0] blk_dst,
  input logic        blk_done,
  input logic        blk_irq,
  input logic        xfer_done
);
  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr) && $stable(rd_req_master));
  assert_wr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));
  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_req_valid, wr_valid, blk_valid}));
  assert_rd_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> rd_req_addr[1:0] == 2'b00);
  assert_blk_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && !blk_ready && !abort |=> blk_valid && $stable(blk_src) && $stable(blk_dst));
  assert_blk_after_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blk_valid) |-> $past(rd_rsp_valid));
  assert_wb_after_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> $past(blk_done));
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> !busy);
  assert_abort_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort && busy |=> !xfer_done && !blk_irq);
endmodule

bind dma_chain_walker dma_chain_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .abort(abort), .busy(busy),
  .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
  .rd_req_addr(rd_req_addr), .rd_req_master(rd_req_master),
  .rd_rsp_valid(rd_rsp_valid), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_addr(wr_addr), .wr_data(wr_data), .blk_valid(blk_valid),
  .blk_ready(blk_ready), .blk_src(blk_src), .blk_dst(blk_dst),
  .blk_done(blk_done), .blk_irq(blk_irq), .xfer_done(xfer_done)
);

// File: tb/dma_chain_walker_tb.sv
`timescale 1ns/1ps
module dma_chain_walker_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic start = 1'b0, abort = 1'b0;
  logic [31:0] head_ptr = '0;
  logic busy, rd_req_valid, wr_valid, blk_valid, blk_irq, xfer_done;
  logic rd_req_ready = 1'b0, rd_rsp_valid = 1'b0, wr_ready = 1'b0, blk_ready = 1'b0, blk_done = 1'b0;
  logic [31:0] rd_req_addr, wr_addr, wr_data, blk_src, blk_dst;
  logic [31:0] rd_rsp_data = '0, blk_src_stat = '0, blk_dst_stat = '0;
  logic [1:0]  rd_req_master, wr_master, blk_dir;
  logic [11:0] blk_size;

  dma_chain_walker u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .head_ptr(head_ptr), .abort(abort), .busy(busy),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_req_master(rd_req_master), .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_master(wr_master),
    .wr_data(wr_data), .blk_valid(blk_valid), .blk_ready(blk_ready), .blk_src(blk_src),
    .blk_dst(blk_dst), .blk_size(blk_size), .blk_dir(blk_dir), .blk_done(blk_done),
    .blk_src_stat(blk_src_stat), .blk_dst_stat(blk_dst_stat), .blk_irq(blk_irq),
    .xfer_done(xfer_done));

  logic [31:0] mem [0:255];
  logic [33:0] q_rd[$];
  logic [77:0] q_blk[$];
  logic [65:0] q_wr[$];
  int n_cmp = 0, n_bad = 0, cyc = 0, nrd = 0, n_xd = 0, n_irq = 0, done_cnt = 0;
  bit loose_rd = 1'b0, rsp_pend = 1'b0;
  logic [31:0] rsp_addr = '0, eng_src = '0, eng_dst = '0;

  task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_desc(input int base, input logic [1:0] m, input logic [31:0] src, dst, nxt, clo,
                          input logic [11:0] sz, input bit expect_run, input bit expect_wb);
    logic [31:0] chi;
    chi = 32'hA5C0_0000 | {20'd0, sz};
    mem[base/4+0] = src; mem[base/4+1] = dst; mem[base/4+2] = nxt;
    mem[base/4+3] = clo; mem[base/4+4] = chi;
    mem[base/4+5] = 32'h0; mem[base/4+6] = 32'h0;
    if (expect_run) begin
      for (int i = 0; i < 5; i++) q_rd.push_back({m, 32'(base + 4*i)});
      q_blk.push_back({src, dst, sz, clo[21:20]});
    end
    if (expect_wb) begin
      q_wr.push_back({m, 32'(base + 16), chi | 32'h1000});
      q_wr.push_back({m, 32'(base + 20), src ^ 32'h0000_FFFF});
      q_wr.push_back({m, 32'(base + 24), dst ^ 32'hFFFF_0000});
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (xfer_done) n_xd++;
    if (blk_irq) n_irq++;
    if (rsp_pend) begin
      rd_rsp_valid = 1'b1; rd_rsp_data = mem[rsp_addr[9:2]]; rsp_pend = 1'b0;
    end else rd_rsp_valid = 1'b0;
    rd_req_ready = (cyc % 3) != 1;
    if (rd_req_valid && rd_req_ready) begin
      nrd++;
      rsp_pend = 1'b1; rsp_addr = rd_req_addr;
      if (!loose_rd) begin
        if (q_rd.size() == 0) chk(0, "R2 unexpected read", {rd_req_master, rd_req_addr}, 0);
        else begin
          logic [33:0] e;
          e = q_rd.pop_front();
          chk({rd_req_master, rd_req_addr} == e, "R2/R5 read addr+master", {rd_req_master, rd_req_addr}, e);
        end
      end
    end
    wr_ready = (cyc % 2) == 0;
    if (wr_valid && wr_ready) begin
      if (q_wr.size() == 0) chk(0, "R4/R8 unexpected write", {wr_master, wr_addr, wr_data}, 0);
      else begin
        logic [65:0] e;
        e = q_wr.pop_front();
        chk({wr_master, wr_addr, wr_data} == e, "R4 write-back", {wr_master, wr_addr, wr_data}, e);
      end
      mem[wr_addr[9:2]] = wr_data;
    end
    blk_done = 1'b0;
    if (done_cnt > 0) begin
      if (done_cnt == 1) begin
        blk_done = 1'b1;
        blk_src_stat = eng_src ^ 32'h0000_FFFF;
        blk_dst_stat = eng_dst ^ 32'hFFFF_0000;
      end
      done_cnt--;
    end
    blk_ready = cyc[0];
    if (blk_valid && blk_ready) begin
      if (q_blk.size() == 0) chk(0, "R3/R8 unexpected hand-off", {blk_src, blk_dst, blk_size, blk_dir}, 0);
      else begin
        logic [77:0] e;
        e = q_blk.pop_front();
        chk({blk_src, blk_dst, blk_size, blk_dir} == e, "R3 hand-off fields", {blk_src, blk_dst, blk_size, blk_dir}, e);
      end
      eng_src = blk_src; eng_dst = blk_dst; done_cnt = 3;
    end
  end

  task automatic kick(input logic [31:0] p);
    @(negedge clk); head_ptr = p; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_end(input int xd0);
    int t = 0;
    while (n_xd == xd0 && t < 5000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic queues_empty(input string req);
    chk(q_rd.size() == 0, {req, " reads consumed"}, q_rd.size(), 0);
    chk(q_blk.size() == 0, {req, " hand-offs consumed"}, q_blk.size(), 0);
    chk(q_wr.size() == 0, {req, " writes consumed"}, q_wr.size(), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int xd0, irq0, nrd0;
    for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_0000 + 32'(i);
    repeat (3) @(negedge clk);
    chk({busy, rd_req_valid, wr_valid, blk_valid, blk_irq, xfer_done} == 6'b0, "R1 reset idle",
        {busy, rd_req_valid, wr_valid, blk_valid, blk_irq, xfer_done}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(busy == 1'b0, "R1 idle after reset", busy, 0);

    // single block: chaining bits clear, next-pointer non-zero (R6, R7)
    put_desc(32'h040, 2'd0, 32'h1000_0000, 32'h2000_0000, 32'h0000_0100, 32'h0010_0001, 12'd7, 1, 1);
    xd0 = n_xd; irq0 = n_irq;
    kick(32'h0000_0040);
    wait_end(xd0);
    chk(n_xd == xd0 + 1, "R6 single block ends walk", n_xd - xd0, 1);
    chk(n_irq == irq0 + 1, "R7 irq with bit0", n_irq - irq0, 1);
    chk(mem[16 + 2] == 32'h0000_0100 && mem[16 + 3] == 32'h0010_0001, "R4 words 0..12 untouched",
        {mem[18], mem[19]}, {32'h100, 32'h0010_0001});
    queues_empty("R2/R3/R4 single");

    // three-descriptor chain with master bits, start while busy (R5, R7, R9)
    put_desc(32'h080, 2'd1, 32'h1111_0000, 32'h2222_0000, 32'h0000_00C2, 32'h0820_0000, 12'd4095, 1, 1);
    put_desc(32'h0C0, 2'd2, 32'h3333_0000, 32'h4444_0000, 32'h0000_0203, 32'h1030_0001, 12'd1, 1, 1);
    put_desc(32'h200, 2'd3, 32'h5555_0000, 32'h6666_0000, 32'h0000_0000, 32'h0800_0000, 12'd0, 1, 1);
    xd0 = n_xd; irq0 = n_irq;
    kick(32'h0000_0081);
    repeat (6) @(negedge clk);
    kick(32'h0000_0300);
    wait_end(xd0);
    chk(n_xd == xd0 + 1, "R5/R6 chain ends on zero pointer", n_xd - xd0, 1);
    chk(n_irq == irq0 + 1, "R7 irq only from middle block", n_irq - irq0, 1);
    chk(mem[32'h200/4 + 4][12] == 1'b1, "R4 done bit in last descriptor", mem[32'h200/4 + 4], 32'h1000);
    queues_empty("R5/R9 chain");

    // next-pointer with only master bits set ends walk (R6)
    put_desc(32'h140, 2'd0, 32'h7777_0000, 32'h8888_0000, 32'h0000_0003, 32'h1800_0000, 12'd9, 1, 1);
    xd0 = n_xd; irq0 = n_irq;
    kick(32'h0000_0140);
    wait_end(xd0);
    chk(n_xd == xd0 + 1, "R6 zero address with master bits stops", n_xd - xd0, 1);
    chk(n_irq == irq0, "R7 no irq with bit0 clear", n_irq - irq0, 0);
    queues_empty("R6 master-only pointer");

    // abort during fetch (R8)
    put_desc(32'h300, 2'd0, 32'h9999_0000, 32'hAAAA_0000, 32'h0000_0000, 32'h0000_0001, 12'd3, 0, 0);
    loose_rd = 1'b1; nrd0 = nrd; xd0 = n_xd; irq0 = n_irq;
    kick(32'h0000_0300);
    while (nrd < nrd0 + 2) @(negedge clk);
    abort = 1'b1; @(negedge clk); abort = 1'b0;
    repeat (30) @(negedge clk);
    chk(busy == 1'b0, "R8 idle after fetch abort", busy, 0);
    chk(nrd <= nrd0 + 3, "R8 reads stop after abort", nrd - nrd0, 3);
    chk(n_xd == xd0 && n_irq == irq0, "R8 no pulses on abort", {n_xd - xd0, n_irq - irq0}, 0);
    chk(mem[32'h300/4 + 4] == 32'hA5C0_0003, "R8 no write-back on abort", mem[32'h300/4 + 4], 32'hA5C0_0003);
    loose_rd = 1'b0;
    queues_empty("R8 fetch abort");

    // abort during block wait (R8)
    put_desc(32'h380, 2'd0, 32'hBBBB_0000, 32'hCCCC_0000, 32'h0000_0000, 32'h0000_0001, 12'd5, 1, 0);
    xd0 = n_xd; irq0 = n_irq;
    kick(32'h0000_0380);
    while (q_blk.size() != 0) @(negedge clk);
    abort = 1'b1; @(negedge clk); abort = 1'b0;
    repeat (20) @(negedge clk);
    chk(busy == 1'b0, "R8 idle after block-wait abort", busy, 0);
    chk(n_xd == xd0 && n_irq == irq0, "R8 no pulses on block abort", {n_xd - xd0, n_irq - irq0}, 0);
    chk(mem[32'h380/4 + 4] == 32'hA5C0_0005, "R8 descriptor untouched", mem[32'h380/4 + 4], 32'hA5C0_0005);
    queues_empty("R8 block abort");

    // recovery after abort
    put_desc(32'h040, 2'd0, 32'hDDDD_0000, 32'hEEEE_0000, 32'h0000_0000, 32'h0020_0000, 12'd2, 1, 1);
    xd0 = n_xd;
    kick(32'h0000_0040);
    wait_end(xd0);
    chk(n_xd == xd0 + 1, "R6 walk after abort completes", n_xd - xd0, 1);
    queues_empty("R2/R3/R4 recovery");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule